// File: doc/BRIEF.md
# Slew-Tracking DAC Calibration Controller

This block is the digital side of a sample-and-hold calibrator. It drives a 12-bit code into an external DAC. It reads an external comparator that reports whether the DAC output is above or below a sampled reference voltage. It also keeps the calibrated code in an external non-volatile store.

At reset the block reads the stored code, drives it to the DAC, and only then listens to the active-low adjust pin. A calibration starts once that pin has been low for a qualifying number of clock cycles. The block then moves the code by one LSB at each step interval, in the direction the comparator asks for. It stops when the comparator direction flips or the code reaches either end of its range. Finally it writes the code to the store and holds for the store time before it signals completion.

The adjust time scales with the size of the code change, because the code always slews one LSB per step. Any number of calibrations may follow one another, and each one begins from the code currently held.

Top module: `cal_tracker`

## Requirements
- R1: After reset the block holds `nv_rd_req` high until `nv_rd_valid` arrives. It then drives `nv_rd_data` on `dac_code`. During reset `dac_code` is 0, and `busy`, `done` and `nv_wr_req` are low. No calibration can start while the load is pending.
- R2: A calibration starts (`busy` rises) only after the synchronized `adj_n` has been sampled low on QUAL_CYC consecutive cycles. Because of the two-stage input synchronizer, `busy` goes high at the (QUAL_CYC+2)-th rising edge after `adj_n` falls. A low pulse one cycle shorter than QUAL_CYC starts nothing.
- R3: Once a calibration has started, `adj_n` has no effect until `done`. This covers early release and toggling. A new calibration needs `adj_n` to be seen high in idle first, so a pin still held low at completion starts nothing. Outside a calibration or the reset load, `dac_code` does not change.
- R4: During a calibration `dac_code` changes by exactly one LSB at a time. Evaluations occur every STEP_CYC cycles, and the first comes STEP_CYC cycles after `busy` rises.
- R5: At each evaluation, `cmp_above` = 1 steps the code down and `cmp_above` = 0 steps it up.
- R6: The adjust phase ends at the first evaluation whose direction is opposite to the previous step. No step is applied at that evaluation, so the final code is the last one applied.
- R7: The code saturates at 0 and 4095. A step that lands on either limit ends the adjust phase. An evaluation that asks to move past a limit ends it with no change.
- R8: At the end of the adjust phase, `nv_wr_req` pulses for one cycle with `nv_wr_data` equal to the final code. `done` follows STORE_CYC cycles after that pulse, but never while `nv_busy` is high.
- R9: `busy` stays high from the start of a calibration through the end of the store. `done` is a one-cycle pulse in the cycle in which `busy` has just fallen.
- R10: Each later calibration starts from the code currently held, whether it came from the last calibration or from the reset load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adj_n | input | 1 | Active-low adjust request, asynchronous |
| cmp_above | input | 1 | Comparator: DAC output above sampled input |
| nv_rd_req | output | 1 | Read request to the non-volatile store |
| nv_rd_valid | input | 1 | Read data valid strobe |
| nv_rd_data | input | 12 | Stored code returned by the read |
| nv_wr_req | output | 1 | One-cycle write request |
| nv_wr_data | output | 12 | Code to be written |
| nv_busy | input | 1 | Store is still programming |
| dac_code | output | 12 | Code driven to the DAC |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses QUAL_CYC = 5, STEP_CYC = 4 and STORE_CYC = 6, with the code width left at 12 bits. The short step interval makes complete rail-to-rail slews affordable: a full 4095-LSB climb to the top limit and a full descent to zero each take only a few thousand evaluations. The small qualify count lets the bench test both sides of the qualification boundary to the exact cycle. Setting the store busy time both under and over STORE_CYC exercises both conditions that gate `done`.

// File: rtl/cal_tracker.sv
module cal_tracker #(
  parameter int CODE_W    = 12,
  parameter int QUAL_CYC  = 16,
  parameter int STEP_CYC  = 64,
  parameter int STORE_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adj_n,
  input  logic              cmp_above,
  output logic              nv_rd_req,
  input  logic              nv_rd_valid,
  input  logic [CODE_W-1:0] nv_rd_data,
  output logic              nv_wr_req,
  output logic [CODE_W-1:0] nv_wr_data,
  input  logic              nv_busy,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              done
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int SW = $clog2(STEP_CYC + 1);
  localparam int WW = $clog2(STORE_CYC + 1);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  typedef enum logic [1:0] {S_LOAD, S_IDLE, S_TRACK, S_STORE} st_t;
  st_t st;

  logic [1:0]        adj_sync;
  logic              armed;
  logic [QW-1:0]     q_cnt;
  logic [SW-1:0]     s_cnt;
  logic [WW-1:0]     w_cnt;
  logic              have_dir, last_dn;
  logic [CODE_W-1:0] code;

  wire               adj_hi    = adj_sync[1];
  wire               tick      = (s_cnt == SW'(STEP_CYC - 1));
  wire               want_dn   = cmp_above;
  wire               at_wall   = want_dn ? (code == '0) : (code == CODE_TOP);
  wire               flip      = have_dir && (want_dn != last_dn);
  wire [CODE_W-1:0]  next_code = want_dn ? code - 1'b1 : code + 1'b1;
  wire               next_wall = want_dn ? (next_code == '0) : (next_code == CODE_TOP);
  wire               stop      = flip || at_wall || next_wall;

  assign nv_rd_req  = (st == S_LOAD);
  assign nv_wr_data = code;
  assign dac_code   = code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_LOAD;
      adj_sync  <= '0;
      armed     <= 1'b0;
      q_cnt     <= '0;
      s_cnt     <= '0;
      w_cnt     <= '0;
      have_dir  <= 1'b0;
      last_dn   <= 1'b0;
      code      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      nv_wr_req <= 1'b0;
    end else begin
      adj_sync  <= {adj_sync[0], adj_n};
      nv_wr_req <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_LOAD: begin
          if (nv_rd_valid) begin
            code <= nv_rd_data;
            st   <= S_IDLE;
          end
        end
        S_IDLE: begin
          if (adj_hi) begin
            armed <= 1'b1;
            q_cnt <= '0;
          end else if (armed) begin
            if (q_cnt == QW'(QUAL_CYC - 1)) begin
              armed    <= 1'b0;
              q_cnt    <= '0;
              s_cnt    <= '0;
              have_dir <= 1'b0;
              busy     <= 1'b1;
              st       <= S_TRACK;
            end else begin
              q_cnt <= q_cnt + 1'b1;
            end
          end
        end
        S_TRACK: begin
          if (!tick) begin
            s_cnt <= s_cnt + 1'b1;
          end else begin
            s_cnt <= '0;
            if (!flip && !at_wall) begin
              code     <= next_code;
              have_dir <= 1'b1;
              last_dn  <= want_dn;
            end
            if (stop) begin
              nv_wr_req <= 1'b1;
              w_cnt     <= '0;
              st        <= S_STORE;
            end
          end
        end
        S_STORE: begin
          if (w_cnt != WW'(STORE_CYC - 1)) begin
            w_cnt <= w_cnt + 1'b1;
          end else if (!nv_busy) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/cal_tracker_chk.sv
module cal_tracker_chk #(
  parameter int CODE_W   = 12,
  parameter int STEP_CYC = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              nv_wr_req,
  input logic              nv_rd_req,
  input logic [CODE_W-1:0] dac_code
);
  logic [CODE_W-1:0] prv;
  int                gap;
  wire               chg = (dac_code != prv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv <= '0;
      gap <= 0;
    end else begin
      prv <= dac_code;
      gap <= !busy ? 0 : (chg ? 1 : gap + 1);
    end
  end

  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R9
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_WR_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) nv_wr_req |=> !nv_wr_req); // R8
  AST_WR_IN_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) nv_wr_req |-> busy); // R8
  AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) nv_rd_req |-> !busy); // R1
  AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (!busy && !nv_rd_req) |=> $stable(dac_code)); // R3
  AST_ONE_LSB:       assert property (@(posedge clk) disable iff (!rst_n) (busy && chg) |-> (dac_code == prv + 1'b1 || dac_code == prv - 1'b1)); // R4
  AST_STEP_SPACING:  assert property (@(posedge clk) disable iff (!rst_n) (busy && chg) |-> (gap == STEP_CYC)); // R4
endmodule

bind cal_tracker cal_tracker_chk #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .nv_wr_req(nv_wr_req), .nv_rd_req(nv_rd_req), .dac_code(dac_code)
);

// File: tb/sim_cal_tracker.sv
`timescale 1ns/1ps
module sim_cal_tracker;
  localparam int QUAL = 5, STEP = 4, STORE = 6;

  logic        clk = 1'b0, rst_n = 1'b0, adj_n = 1'b1;
  logic        cmp_above, nv_rd_req, nv_wr_req, nv_busy, busy, done;
  logic        nv_rd_valid = 1'b0;
  logic [11:0] nv_rd_data, nv_wr_data, dac_code;

  int total = 0, bad = 0;
  int tgt = 0;
  int mem = 1443, bcnt = 0, blen = STORE - 2, rcnt = 0;

  always #2.5 clk = ~clk;

  assign cmp_above  = (int'(dac_code) > tgt);
  assign nv_busy    = (bcnt > 0);
  assign nv_rd_data = 12'(mem);

  always @(posedge clk) begin
    if (nv_wr_req) begin mem <= int'(nv_wr_data); bcnt <= blen; end
    else if (bcnt > 0) bcnt <= bcnt - 1;
    if (nv_rd_req && !nv_rd_valid) begin
      if (rcnt == 2) begin nv_rd_valid <= 1'b1; rcnt <= 0; end
      else rcnt <= rcnt + 1;
    end else nv_rd_valid <= 1'b0;
  end

  cal_tracker #(.CODE_W(12), .QUAL_CYC(QUAL), .STEP_CYC(STEP), .STORE_CYC(STORE)) u0 (
    .clk(clk), .rst_n(rst_n), .adj_n(adj_n), .cmp_above(cmp_above),
    .nv_rd_req(nv_rd_req), .nv_rd_valid(nv_rd_valid), .nv_rd_data(nv_rd_data),
    .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data), .nv_busy(nv_busy),
    .dac_code(dac_code), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic adj_lvl, input int exp_code);
    int n;
    adj_n = adj_lvl;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "reset dac_code", int'(dac_code), 0);
    chk("R1", "reset busy/done/wr", int'({busy, done, nv_wr_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "load request after reset", int'(nv_rd_req), 1);
    n = 0;
    while (nv_rd_req && n < 50) begin @(negedge clk); n++; end
    chk("R1", "restored code", int'(dac_code), exp_code);
  endtask

  function automatic void predict(input int c, input int t, output int fin, output int ticks);
    if (t >= 4095) begin fin = 4095; ticks = (c == 4095) ? 1 : 4095 - c; end
    else if (t < 0) begin fin = 0; ticks = (c == 0) ? 1 : c; end
    else if (c <= t) begin fin = t + 1; ticks = t + 2 - c; end
    else begin fin = t; ticks = c - t + 1; end
  endfunction

  // mode 0: hold adj low to the end; 1: release once busy; 2: toggle while busy; 3: exact QUAL pulse
  task automatic run_cal(input int t, input int mode, input int blen_v);
    int c0, fin, ticks, n, m, k, first, busy_drop, done_wait;
    c0 = int'(dac_code);
    predict(c0, t, fin, ticks);
    tgt = t;
    blen = blen_v;
    done_wait = (STORE > blen_v + 2) ? STORE : blen_v + 2;
    first = (c0 > t) ? c0 - 1 : c0 + 1;
    busy_drop = 0;
    adj_n = 1'b0;
    n = 0;
    while (!busy && n < 100) begin
      @(negedge clk); n++;
      if (mode == 3 && n == QUAL) adj_n = 1'b1;
    end
    chk("R2", "cycles adj low to busy", n, QUAL + 2);
    if (mode == 1) adj_n = 1'b1;
    m = 0;
    while (!nv_wr_req && m < 20000) begin
      @(negedge clk); m++;
      if (mode == 2) adj_n = ~adj_n;
      if (!busy) busy_drop++;
      if (m == STEP && !((c0 == 0 && t < 0) || (c0 == 4095 && t >= 4095)))
        chk("R5", "first step direction", int'(dac_code), first);
    end
    chk("R4", "adjust cycles", m, ticks * STEP);
    chk("R6", "final code (R7 at limits)", int'(dac_code), fin);
    chk("R8", "write data", int'(nv_wr_data), fin);
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk); k++;
      if (mode == 2) adj_n = ~adj_n;
      if (!done && !busy) busy_drop++;
    end
    chk("R8", "write to done cycles", k, done_wait);
    chk("R9", "busy held until store end", busy_drop, 0);
    chk("R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R9", "done single cycle", int'(done), 0);
    if (mode == 0) begin
      n = 0;
      repeat (3 * QUAL) begin @(negedge clk); if (busy) n++; end
      chk("R3", "no restart while held low", n, 0);
    end
    adj_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", "code kept in idle", int'(dac_code), fin);
  endtask

  task automatic short_pulse;
    int n;
    int c0;
    c0 = int'(dac_code);
    adj_n = 1'b0;
    repeat (QUAL - 1) @(negedge clk);
    adj_n = 1'b1;
    n = 0;
    repeat (20) begin @(negedge clk); if (busy) n++; end
    chk("R2", "short pulse ignored", n, 0);
    chk("R2", "code unchanged after short pulse", int'(dac_code), c0);
  endtask

  task automatic held_through_reset;
    int n;
    do_reset(1'b0, 0);
    n = 0;
    repeat (3 * QUAL) begin @(negedge clk); if (busy) n++; end
    chk("R1", "no start with adj low through load", n, 0);
    adj_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b1, 1443);
    short_pulse();
    run_cal(1500, 1, STORE - 2);
    run_cal(1400, 2, STORE - 2);
    run_cal(1400, 3, STORE - 2);
    run_cal(1390, 0, STORE + 3);
    run_cal(4095, 1, STORE - 2);
    run_cal(-1, 1, STORE - 2);
    run_cal(-1, 1, STORE - 2);
    held_through_reset();
    run_cal(10, 1, STORE - 2); // R10: starts from the code restored by the load
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule